// File: doc/BRIEF.md
# Prioritized interrupt request selector

This block collects the interrupt request lines of a small processor core and tells the core which single request it should take next. Along with the choice it gives the cause number the core uses to identify the trap. The sources are a non-maskable line, a bank of fast local lines, a line from an external interrupt controller, a timer line and a software (inter-processor) line. Each source has a fixed, sparse cause number. When several requests are eligible in the same cycle, the highest number wins.

Maskable sources take part only when the global enable is set and the source's own enable bit is set. Each enable bit sits at the same position as the source's cause number. The non-maskable line ignores every enable. A rising edge on it sets a sticky pending bit, and the core clears that bit by acknowledging while cause 31 is on the output. All inputs are sampled once into registers before the choice is made. A registered 32-bit pending vector shows the raw, unmasked state of every source at its cause position.

Top module: `irq_prio_select`

## Requirements
- R1: A pending non-maskable request is reported with `irqValid` = 1 and `irqId` = 31.
- R2: Fast line `fastReq[n]` (n = 0..14) is reported with cause number 16+n. Lines held low never affect the choice.
- R3: The external-controller line is reported as cause 11, the timer line as cause 7 and the software line as cause 3.
- R4: When several eligible requests coexist, `irqId` is the numerically highest eligible cause number.
- R5: A maskable request is eligible only if `globalEn` is 1 and `srcEn[c]` is 1, where c is that source's cause number.
- R6: The non-maskable request is eligible regardless of `globalEn` and `srcEn`.
- R7: Every input is registered once. Outputs reflect an input change after exactly one rising clock edge and do not change before it.
- R8: A 0-to-1 transition of `nmiReq` sets a sticky pending bit. The bit stays set until `ack` is 1 at a clock edge while `irqId` is 31. A level held high after such a clear does not set it again; only a new rising transition does.
- R9: `ack` asserted while a cause other than 31 is presented, or while nothing is presented, changes no output.
- R10: When no request is eligible, `irqValid` is 0 and `irqId` is 0.
- R11: `pendVec` bit c shows the registered raw (unmasked) state of the source with cause c. Bit 31 shows the sticky non-maskable bit, and all unused bit positions read 0.
- R12: While `rstN` is 0, the pending non-maskable bit, the registered requests and all registered enables are cleared, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| nmiReq | input | 1 | Non-maskable request, edge-captured |
| fastReq | input | 15 | Fast local request lines, level |
| extReq | input | 1 | External interrupt-controller request, level |
| timerReq | input | 1 | Timer request, level |
| softReq | input | 1 | Software request, level |
| globalEn | input | 1 | Global enable for maskable sources |
| srcEn | input | 32 | Per-source enables, bit index = cause number |
| ack | input | 1 | Core acknowledge of the presented cause |
| irqValid | output | 1 | An eligible request is being presented |
| irqId | output | 5 | Cause number of the presented request |
| pendVec | output | 32 | Registered raw pending state per cause number |

## Verification
The bench builds the block with its default of fifteen fast lines at base cause 16. That makes the whole 32-bit cause space reachable: bit 31 for the non-maskable line, bits 16..30 for the fast lines, and the sparse low positions 11, 7 and 3, with every other position left as an unused hole. Because every fast line exists at this setting, the bench can sweep each line to its own cause number, collide the top fast line with the non-maskable bit, and confirm that the gaps between 3, 7, 11 and 16 never show up in the pending vector.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int VEC_W     = 32;
  localparam int ID_W      = $clog2(VEC_W);
  localparam int NMI_ID    = 31;
  localparam int FAST_BASE = 16;
  localparam int EXT_ID    = 11;
  localparam int TMR_ID    = 7;
  localparam int SW_ID     = 3;

  // strobes from control to datapath for the sticky non-maskable bit
  typedef struct packed {
    logic setNmi;
    logic clrNmi;
  } nmiStrobe_t;

  // positions of the vector that belong to a real source
  function automatic logic [VEC_W-1:0] usedMask(int nFast);
    logic [VEC_W-1:0] m;
    m = '0;
    for (int n = 0; n < nFast; n++) m[FAST_BASE+n] = 1'b1;
    m[NMI_ID] = 1'b1;
    m[EXT_ID] = 1'b1;
    m[TMR_ID] = 1'b1;
    m[SW_ID]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_sel_prienc.sv
module irq_sel_prienc #(
  parameter int W = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             anySet,
  output logic [IDX_W-1:0] topIdx
);
  // scan upward so the highest set bit is the last one written
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) topIdx = IDX_W'(i);
    end
  end

  assign anySet = |vec;
endmodule

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic            nmiIn,
  input  logic            nmiLast,
  input  logic            ack,
  input  logic            selValid,
  input  logic [ID_W-1:0] selId,
  output nmiStrobe_t      strobe
);
  always_comb begin
    strobe.setNmi = nmiIn & ~nmiLast;
    strobe.clrNmi = ack & selValid & (selId == ID_W'(NMI_ID));
  end
endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
#(
  parameter int NUM_FAST = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                nmiIn,
  input  logic [NUM_FAST-1:0] fastIn,
  input  logic                extIn,
  input  logic                tmrIn,
  input  logic                swIn,
  input  logic                gieIn,
  input  logic [VEC_W-1:0]    enIn,
  input  nmiStrobe_t          strobe,
  output logic                nmiLast,
  output logic [VEC_W-1:0]    eligible,
  output logic [VEC_W-1:0]    pendRaw
);
  localparam logic [VEC_W-1:0] USED    = usedMask(NUM_FAST);
  localparam logic [VEC_W-1:0] NMI_BIT = VEC_W'(1) << NMI_ID;

  logic [VEC_W-1:0] fastMap;
  logic [VEC_W-1:0] rawMap;
  logic [VEC_W-1:0] reqReg;
  logic [VEC_W-1:0] enReg;
  logic             gieReg;
  logic             nmiPend;

  // place each fast line at its own cause position
  for (genvar n = 0; n < VEC_W; n++) begin : g_fastMap
    if (n >= FAST_BASE && n < FAST_BASE + NUM_FAST) begin : g_line
      assign fastMap[n] = fastIn[n-FAST_BASE];
    end else begin : g_hole
      assign fastMap[n] = 1'b0;
    end
  end

  always_comb begin
    rawMap         = fastMap;
    rawMap[EXT_ID] = extIn;
    rawMap[TMR_ID] = tmrIn;
    rawMap[SW_ID]  = swIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReg  <= '0;
      enReg   <= '0;
      gieReg  <= 1'b0;
      nmiLast <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      reqReg  <= rawMap;
      enReg   <= enIn & USED & ~NMI_BIT;
      gieReg  <= gieIn;
      nmiLast <= nmiIn;
      if (strobe.setNmi)      nmiPend <= 1'b1;
      else if (strobe.clrNmi) nmiPend <= 1'b0;
    end
  end

  assign eligible = (reqReg & enReg & {VEC_W{gieReg}}) | (nmiPend ? NMI_BIT : '0);
  assign pendRaw  = reqReg | (nmiPend ? NMI_BIT : '0);
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_sel_pkg::*;
#(
  parameter int NUM_FAST = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                nmiReq,
  input  logic [NUM_FAST-1:0] fastReq,
  input  logic                extReq,
  input  logic                timerReq,
  input  logic                softReq,
  input  logic                globalEn,
  input  logic [VEC_W-1:0]    srcEn,
  input  logic                ack,
  output logic                irqValid,
  output logic [ID_W-1:0]     irqId,
  output logic [VEC_W-1:0]    pendVec
);
  nmiStrobe_t       strobe;
  logic             nmiLast;
  logic [VEC_W-1:0] eligible;

  irq_sel_dp #(.NUM_FAST(NUM_FAST)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .nmiIn    (nmiReq),
    .fastIn   (fastReq),
    .extIn    (extReq),
    .tmrIn    (timerReq),
    .swIn     (softReq),
    .gieIn    (globalEn),
    .enIn     (srcEn),
    .strobe   (strobe),
    .nmiLast  (nmiLast),
    .eligible (eligible),
    .pendRaw  (pendVec)
  );

  irq_sel_prienc #(.W(VEC_W)) u_enc (
    .vec    (eligible),
    .anySet (irqValid),
    .topIdx (irqId)
  );

  irq_sel_ctrl u_ctrl (
    .nmiIn    (nmiReq),
    .nmiLast  (nmiLast),
    .ack      (ack),
    .selValid (irqValid),
    .selId    (irqId),
    .strobe   (strobe)
  );
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk
  import irq_sel_pkg::*;
#(
  parameter int NUM_FAST = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             nmiReq,
  input logic             globalEn,
  input logic             ack,
  input logic             irqValid,
  input logic [ID_W-1:0]  irqId,
  input logic [VEC_W-1:0] pendVec
);
  localparam logic [VEC_W-1:0] USED = usedMask(NUM_FAST);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> irqId == '0);

  // R6
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendVec[NMI_ID] |-> (irqValid && irqId == ID_W'(NMI_ID)));

  // R4
  sel_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> pendVec[irqId]);

  // R5
  gie_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(globalEn) && !pendVec[NMI_ID]) |-> !irqValid);

  // R8
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[NMI_ID] && !(ack && irqId == ID_W'(NMI_ID))) |=> pendVec[NMI_ID]);

  // R8
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[NMI_ID] && ack && irqId == ID_W'(NMI_ID) && !nmiReq) |=> !pendVec[NMI_ID]);

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & ~USED) == '0);
endmodule

bind irq_prio_select irq_prio_select_chk #(.NUM_FAST(NUM_FAST)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .nmiReq   (nmiReq),
  .globalEn (globalEn),
  .ack      (ack),
  .irqValid (irqValid),
  .irqId    (irqId),
  .pendVec  (pendVec)
);

// File: tb/sim_irq_prio_select.sv
`timescale 1ns/1ps
module sim_irq_prio_select;
  logic        clk = 1'b0;
  logic        rstN;
  logic        nmiReq;
  logic [14:0] fastReq;
  logic        extReq, timerReq, softReq, globalEn, ack;
  logic [31:0] srcEn;
  logic        irqValid;
  logic [4:0]  irqId;
  logic [31:0] pendVec;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  // bench model state
  logic [31:0] mReq, mEn;
  logic        mGie, mNmiPend, mNmiLast;

  always #2 clk = ~clk;

  irq_prio_select u0 (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .fastReq(fastReq),
    .extReq(extReq), .timerReq(timerReq), .softReq(softReq),
    .globalEn(globalEn), .srcEn(srcEn), .ack(ack),
    .irqValid(irqValid), .irqId(irqId), .pendVec(pendVec)
  );

  function automatic logic [31:0] mapIn(logic [14:0] f, logic e, logic t, logic s);
    logic [31:0] v = '0;
    for (int n = 0; n < 15; n++) v[16+n] = f[n];
    v[11] = e;
    v[7]  = t;
    v[3]  = s;
    return v;
  endfunction

  // {valid, id}
  function automatic logic [5:0] pick(logic [31:0] req, logic [31:0] en, logic gie, logic nmi);
    logic [31:0] elig = (req & en & {32{gie}}) & 32'h7FFF_FFFF;
    elig[31] = nmi;
    for (int i = 31; i >= 0; i--) if (elig[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  function automatic logic [31:0] expPend();
    logic [31:0] v = mReq;
    v[31] = mNmiPend;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkOut(string tag);
    logic [5:0] e = pick(mReq, mEn, mGie, mNmiPend);
    chk({tag, " valid"}, 32'(irqValid), 32'(e[5]));
    chk({tag, " id"},    32'(irqId),    32'(e[4:0]));
    chk({tag, " pend"},  pendVec,       expPend());
  endtask

  // advance one clock edge and update the model from the applied inputs
  task automatic step();
    logic [5:0] pre = pick(mReq, mEn, mGie, mNmiPend);
    logic clr = ack && pre[5] && (pre[4:0] == 5'd31);
    logic set = nmiReq && !mNmiLast;
    @(posedge clk);
    if (!rstN) begin
      mReq = '0; mEn = '0; mGie = 1'b0; mNmiPend = 1'b0; mNmiLast = 1'b0;
    end else begin
      mReq = mapIn(fastReq, extReq, timerReq, softReq);
      mEn = srcEn;
      mGie = globalEn;
      mNmiLast = nmiReq;
      if (set) mNmiPend = 1'b1;
      else if (clr) mNmiPend = 1'b0;
    end
    #1;
  endtask

  task automatic setReq(logic [14:0] f, logic e, logic t, logic s);
    fastReq = f; extReq = e; timerReq = t; softReq = s;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mReq = '0; mEn = '0; mGie = 1'b0; mNmiPend = 1'b0; mNmiLast = 1'b0;
    rstN = 1'b0; nmiReq = 1'b1; setReq('1, 1, 1, 1);
    globalEn = 1'b1; srcEn = '1; ack = 1'b0;
    // R12: everything held active during reset, outputs stay cleared
    repeat (3) step();
    chk("R12 valid", 32'(irqValid), 0);
    chk("R12 id", 32'(irqId), 0);
    chk("R12 pend", pendVec, 0);

    nmiReq = 1'b0; setReq('0, 0, 0, 0); rstN = 1'b1;
    step();
    checkOut("R10 idle");
    chk("R10 idle id", 32'(irqId), 0);

    // R7: no change before the edge, change after one edge
    setReq(15'h0020, 0, 0, 0);
    #1;
    chk("R7 before edge", 32'(irqValid), 0);
    step();
    chk("R7 after edge", 32'(irqId), 21);

    // R2: each fast line maps to 16+n
    for (int n = 0; n < 15; n++) begin
      setReq(15'(1) << n, 0, 0, 0);
      step();
      chk("R2 fast id", 32'(irqId), 32'(16 + n));
    end
    setReq('1, 0, 0, 0); step();
    chk("R2 all fast", 32'(irqId), 30);

    // R3: sparse low causes
    setReq('0, 1, 0, 0); step(); chk("R3 ext", 32'(irqId), 11);
    setReq('0, 0, 1, 0); step(); chk("R3 timer", 32'(irqId), 7);
    setReq('0, 0, 0, 1); step(); chk("R3 soft", 32'(irqId), 3);

    // R4: priority among coexisting requests
    setReq('0, 1, 1, 1); step(); chk("R4 ext>timer>soft", 32'(irqId), 11);
    setReq('0, 0, 1, 1); step(); chk("R4 timer>soft", 32'(irqId), 7);
    setReq(15'h0001, 1, 1, 1); step(); chk("R4 fast0>ext", 32'(irqId), 16);

    // R5: global enable and per-source enable gate maskable sources
    globalEn = 1'b0; setReq(15'h7FFF, 1, 1, 1); step();
    chk("R5 gie off valid", 32'(irqValid), 0);
    chk("R11 raw shown while masked", pendVec, 32'h7FFF_0888);
    globalEn = 1'b1; srcEn = ~(32'h1 << 11); setReq('0, 1, 0, 0); step();
    chk("R5 src off valid", 32'(irqValid), 0);
    srcEn = ~(32'h1 << 30); setReq(15'h4001, 0, 0, 0); step();
    chk("R5 src30 off picks 16", 32'(irqId), 16);
    srcEn = '1;

    // R1 / R6: NMI with every enable cleared
    globalEn = 1'b0; srcEn = '0; setReq('1, 1, 1, 1); nmiReq = 1'b1; step();
    chk("R1 nmi id", 32'(irqId), 31);
    chk("R6 nmi valid", 32'(irqValid), 1);
    // R8: sticky without ack, then clear with level still high
    repeat (3) step();
    chk("R8 sticky", 32'(pendVec[31]), 1);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R8 cleared", 32'(pendVec[31]), 0);
    repeat (2) step();
    chk("R8 held level no reset", 32'(pendVec[31]), 0);
    nmiReq = 1'b0; step(); nmiReq = 1'b1; step();
    chk("R8 new edge", 32'(pendVec[31]), 1);
    ack = 1'b1; step(); ack = 1'b0; nmiReq = 1'b0;
    checkOut("R8 after ack");

    // R9: ack while another cause is presented
    globalEn = 1'b1; srcEn = '1; setReq('0, 1, 0, 0); step();
    ack = 1'b1; step(); step(); ack = 1'b0;
    chk("R9 id kept", 32'(irqId), 11);
    chk("R9 pend kept", pendVec, 32'h0000_0800);
    setReq('0, 0, 0, 0); step();
    ack = 1'b1; step(); ack = 1'b0;
    chk("R9 idle ack", 32'(irqValid), 0);

    // R4 random mix checked every cycle
    for (int k = 0; k < 3000; k++) begin
      setReq(15'($urandom) & 15'($urandom), ($urandom % 3) == 0,
             ($urandom % 3) == 0, ($urandom % 3) == 0);
      globalEn = ($urandom % 8) != 0;
      srcEn = $urandom | $urandom;
      if (($urandom % 8) == 0) nmiReq = ~nmiReq;
      ack = ($urandom % 4) == 0;
      step();
      checkOut("R4 random");
    end

    // R12: reset mid-run with NMI pending
    nmiReq = 1'b0; step(); nmiReq = 1'b1; step();
    rstN = 1'b0; step();
    chk("R12 mid-run reset", pendVec, 0);
    rstN = 1'b1; nmiReq = 1'b0; step();
    checkOut("R12 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule